// File: doc/BRIEF.md
# Three-Wire Serial Slave Bit Engine

This block is the bit-level front end of a three-wire serial slave. The three wires are an active-high select, a serial clock and one bidirectional data line. Inside the chip the data line is split into an input, an output and an output enable. The select and serial-clock pins are asynchronous to the system clock. They pass through a synchronizer together with the data input, and every edge of the serial clock is detected in the system clock domain.

Each transfer opens with an 8-bit command. The engine checks only the command's valid bit, its direction bit and whether its address field is all ones. From there it either collects write bytes or streams out read bytes, and it talks to a register-access controller through single-cycle strobes. For a read, the engine asks the controller for a byte with a request strobe and takes the byte in that same cycle. It then shifts the byte out on the falling edges of the serial clock.

Top module: `tws_slave`

## Requirements
- R1: While the synchronized select is low, the engine is idle: the data output enable is low, and any partly received bits are discarded. A new transfer begins when select goes high with the serial clock low.
- R2: Bits on the data input are captured on rising serial-clock edges, least significant bit first. After eight captured bits the command is complete. A valid command is handed out with a one-cycle `cmd_stb` and its value on `cmd_byte`.
- R3: A command whose bit 7 is 0 is invalid. For the rest of that transfer there is no `cmd_stb`, no `wr_stb`, no `rd_req`, and the output enable stays low.
- R4: A valid command with bit 0 = 0 is a write. If its address field (bits 5..1) is not all ones, exactly one data byte follows. That byte is delivered with one `wr_stb`, and any later serial-clock cycles in the same transfer are ignored.
- R5: A write command whose bits 5..1 are all ones is a burst write. Every further group of eight rising edges produces one `wr_stb` carrying that byte, for as long as select stays high.
- R6: A valid command with bit 0 = 1 is a read. Bit 0 of the first byte is driven on the falling serial-clock edge that directly follows the eighth command bit. The output changes only on falling edges and holds through the next rising edge.
- R7: A read keeps going for as long as select stays high. One `rd_req` is issued when the command completes, and one more after bit 7 of each byte has been driven. Each request supplies the next byte, sent least significant bit first.
- R8: The output enable is high only from the first falling edge of a valid read's data phase until select goes low.
- R9: The engine samples `rd_byte` in the cycle in which `rd_req` is high. `rd_req` and `wr_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pin | input | 1 | Transfer select from the pad, active high |
| sck_pin | input | 1 | Serial clock from the pad |
| dio_in | input | 1 | Data line input from the pad |
| dio_out | output | 1 | Data line output value to the pad |
| dio_oe | output | 1 | Data line output enable |
| cmd_stb | output | 1 | One-cycle pulse: valid command received |
| cmd_byte | output | 8 | Last valid command byte |
| wr_stb | output | 1 | One-cycle pulse: write byte received |
| wr_byte | output | 8 | Last received write byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_byte | input | 8 | Read byte from the controller, sampled while rd_req is high |

## Verification
The bench sweeps single-byte writes over many data values and follows each with a full byte of extra clocks. A design that did not ignore the extra clocks would produce a second write strobe. Burst writes and reads with several bytes test that the bit counter wraps at each byte boundary. The read checks sample each output bit both just before and just after the rising edge, so an engine that drove the first bit one edge late, or changed the output on rising edges, reports a mismatch. Invalid commands, and transfers cut off in the middle of a command or a read, show whether stale bit counts or a stuck output enable leak into the next transfer.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2,
    PH_IGN = 2'd3
  } phase_t;

  // bit 7 marks a usable command
  function automatic logic cmd_is_valid(input logic [7:0] c);
    return c[7];
  endfunction

  // bit 0 selects the direction: 1 reads, 0 writes
  function automatic logic cmd_is_read(input logic [7:0] c);
    return c[0];
  endfunction

  // an all-ones address field asks for a multi-byte transfer
  function automatic logic cmd_is_burst(input logic [7:0] c);
    return &c[5:1];
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W   = 3,
  parameter int STG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STG];

  genvar g;
  generate
    for (g = 0; g < STG; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STG-1];
endmodule

// File: rtl/tws_edge.sv
module tws_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = en &  lvl & ~prev_q;
  assign fall = en & ~lvl &  prev_q;
endmodule

// File: rtl/tws_rx.sv
module tws_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          din,
  output logic          byte_done,
  output logic [BW-1:0] byte_val
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [BW-1:0] sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (bit_en) begin
      sr_q  <= {din, sr_q[BW-1:1]};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_done = bit_en && (cnt_q == LAST);
  assign byte_val  = {din, sr_q[BW-1:1]};

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr) |=> ($stable(sr_q) && $stable(cnt_q)));

  // R1
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tws_tx.sv
module tws_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic          shift_en,
  output logic          dout,
  output logic          last_bit
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [BW-1:0] buf_q;
  logic [CW-1:0] idx_q;
  logic          dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      idx_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (load) buf_q <= load_val;
      if (clr) begin
        idx_q <= '0;
      end else if (shift_en) begin
        dout_q <= buf_q[idx_q];
        idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign dout     = dout_q;
  assign last_bit = shift_en && (idx_q == LAST);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dout_q));
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int BW  = 8,
  parameter int STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_pin,
  input  logic          sck_pin,
  input  logic          dio_in,
  output logic          dio_out,
  output logic          dio_oe,
  output logic          cmd_stb,
  output logic [BW-1:0] cmd_byte,
  output logic          wr_stb,
  output logic [BW-1:0] wr_byte,
  output logic          rd_req,
  input  logic [BW-1:0] rd_byte
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] pins_s;
  logic sel_s, sck_s, din_s;
  logic sck_rise, sck_fall;
  logic rx_en, rx_done;
  logic [BW-1:0] rx_val;
  logic tx_shift, tx_last;

  phase_t        phase_q;
  logic          burst_q, oe_q;
  logic          cmd_stb_q, wr_stb_q, rd_req_q;
  logic [BW-1:0] cmd_q, wr_q;

  tws_sync #(.W(NSYNC), .STG(STG)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({cs_pin, sck_pin, dio_in}), .q(pins_s)
  );
  assign sel_s = pins_s[2];
  assign sck_s = pins_s[1];
  assign din_s = pins_s[0];

  tws_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .en(sel_s),
    .rise(sck_rise), .fall(sck_fall)
  );

  assign rx_en = sck_rise && (phase_q == PH_CMD || phase_q == PH_WR);

  tws_rx #(.BW(BW)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr(!sel_s), .bit_en(rx_en),
    .din(din_s), .byte_done(rx_done), .byte_val(rx_val)
  );

  assign tx_shift = sck_fall && (phase_q == PH_RD);

  tws_tx #(.BW(BW)) tx_i (
    .clk(clk), .rst_n(rst_n), .clr(!sel_s), .load(rd_req_q),
    .load_val(rd_byte), .shift_en(tx_shift),
    .dout(dio_out), .last_bit(tx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      burst_q   <= 1'b0;
      oe_q      <= 1'b0;
      cmd_stb_q <= 1'b0;
      wr_stb_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      cmd_q     <= '0;
      wr_q      <= '0;
    end else begin
      cmd_stb_q <= 1'b0;
      wr_stb_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      if (!sel_s) begin
        phase_q <= PH_CMD;
        burst_q <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        if (rx_done && phase_q == PH_CMD) begin
          if (!cmd_is_valid(rx_val)) begin
            phase_q <= PH_IGN;
          end else begin
            cmd_stb_q <= 1'b1;
            cmd_q     <= rx_val;
            burst_q   <= cmd_is_burst(rx_val);
            if (cmd_is_read(rx_val)) begin
              phase_q  <= PH_RD;
              rd_req_q <= 1'b1;
            end else begin
              phase_q <= PH_WR;
            end
          end
        end
        if (rx_done && phase_q == PH_WR) begin
          wr_stb_q <= 1'b1;
          wr_q     <= rx_val;
          if (!burst_q) phase_q <= PH_IGN;
        end
        if (tx_shift) begin
          oe_q <= 1'b1;
          if (tx_last) rd_req_q <= 1'b1;
        end
      end
    end
  end

  assign dio_oe   = oe_q;
  assign cmd_stb  = cmd_stb_q;
  assign cmd_byte = cmd_q;
  assign wr_stb   = wr_stb_q;
  assign wr_byte  = wr_q;
  assign rd_req   = rd_req_q;

  // R1
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !dio_oe);

  // R8
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> (phase_q == PH_RD));

  // R3
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IGN) |=> (!wr_stb && !cmd_stb && !rd_req));

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_req));

  // R2
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, wr_stb}));
endmodule

// File: tb/tws_slave_tb.sv
module tws_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_pin = 1'b0, sck_pin = 1'b0, dio_in = 1'b0;
  logic dio_out, dio_oe, cmd_stb, wr_stb, rd_req;
  logic [7:0] cmd_byte, wr_byte, rd_byte;

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_fail = 0;
  int cmd_cnt = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;
  logic [7:0] wr_log [16];
  bit finished = 0;

  function automatic logic [7:0] rd_pat(input int k);
    return 8'h5A ^ 8'(k * 29);
  endfunction

  assign rd_byte = rd_pat(rd_cnt);

  tws_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_pin(cs_pin), .sck_pin(sck_pin),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_req(rd_req), .rd_byte(rd_byte)
  );

  always @(posedge clk) begin
    if (cmd_stb) begin cmd_cnt <= cmd_cnt + 1; last_cmd <= cmd_byte; end
    if (wr_stb) begin
      wr_cnt <= wr_cnt + 1; last_wr <= wr_byte;
      wr_log[wr_cnt % 16] <= wr_byte;
    end
    if (rd_req) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock cycle: low phase, then high phase
  task automatic sbit(input logic b, output logic o_lo, output logic o_hi, output logic oe_lo);
    sck_pin = 1'b0; dio_in = b;
    wait_clk(8);
    o_lo = dio_out; oe_lo = dio_oe;
    sck_pin = 1'b1;
    wait_clk(8);
    o_hi = dio_out;
  endtask

  task automatic begin_xfer();
    sck_pin = 1'b0; cs_pin = 1'b1; wait_clk(8);
  endtask

  task automatic end_xfer();
    sck_pin = 1'b0; wait_clk(4); cs_pin = 1'b0; wait_clk(8);
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic a, b, c;
    for (int i = 0; i < 8; i++) sbit(v[i], a, b, c);
  endtask

  task automatic do_read(input logic [7:0] cmd, input int nbytes);
    int base;
    logic lo, hi, oe;
    base = rd_cnt;
    begin_xfer();
    for (int i = 0; i < 8; i++) begin
      sbit(cmd[i], lo, hi, oe);
      // R8: no drive during the command phase
      chk(oe == 1'b0, "R8", oe, 0);
    end
    for (int j = 0; j < nbytes; j++) begin
      for (int b = 0; b < 8; b++) begin
        logic e;
        e = rd_pat(base + j)[b];
        sbit(1'b0, lo, hi, oe);
        // R6 / R7: LSB first, first bit right after command
        chk(lo == e, (j == 0) ? "R6" : "R7", lo, e);
        // R6: held through the rising edge
        chk(hi == lo, "R6", hi, lo);
        chk(oe == 1'b1, "R8", oe, 1);
      end
    end
    end_xfer();
    // R7 and R9: one request per byte plus the initial one
    chk(rd_cnt == base + nbytes + 1, "R7", rd_cnt - base, nbytes + 1);
    chk(last_cmd == cmd, "R2", last_cmd, cmd);
    // R1: released after select low
    chk(dio_oe == 1'b0, "R1", dio_oe, 0);
  endtask

  initial begin
    int w0, c0, r0;
    logic lo, hi, oe;
    wait_clk(5);
    // R1: reset state
    chk(dio_oe == 1'b0, "R1", dio_oe, 0);
    chk(cmd_stb == 0 && wr_stb == 0 && rd_req == 0, "R1", {cmd_stb, wr_stb, rd_req}, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R4: single-byte write sweep, with trailing clocks ignored
    for (int v = 0; v < 256; v += 15) begin
      logic [7:0] cmd;
      cmd = 8'h80 | 8'((v % 30) << 1) ;
      w0 = wr_cnt; c0 = cmd_cnt;
      begin_xfer();
      send_byte(cmd);
      send_byte(8'(v));
      send_byte(8'hFF);
      send_byte(8'h81);
      end_xfer();
      chk(cmd_cnt == c0 + 1 && last_cmd == cmd, "R2", last_cmd, cmd);
      chk(wr_cnt == w0 + 1, "R4", wr_cnt - w0, 1);
      chk(last_wr == 8'(v), "R4", last_wr, v);
    end

    // R5: burst write of four bytes
    w0 = wr_cnt;
    begin_xfer();
    send_byte(8'hBE);
    for (int k = 0; k < 4; k++) send_byte(8'(8'h11 * (k + 3)));
    end_xfer();
    chk(wr_cnt == w0 + 4, "R5", wr_cnt - w0, 4);
    for (int k = 0; k < 4; k++)
      chk(wr_log[(w0 + k) % 16] == 8'(8'h11 * (k + 3)), "R5",
          wr_log[(w0 + k) % 16], 8'h11 * (k + 3));

    // R3: invalid commands, both directions
    for (int k = 0; k < 4; k++) begin
      logic [7:0] cmd;
      cmd = 8'(k * 37) & 8'h7F;
      w0 = wr_cnt; c0 = cmd_cnt; r0 = rd_cnt;
      begin_xfer();
      send_byte(cmd);
      for (int i = 0; i < 16; i++) begin
        sbit(i[0], lo, hi, oe);
        if (oe) chk(1'b0, "R3", oe, 0);
      end
      chk(oe == 1'b0, "R3", oe, 0);
      end_xfer();
      chk(wr_cnt == w0 && cmd_cnt == c0 && rd_cnt == r0, "R3",
          (wr_cnt - w0) + (cmd_cnt - c0) + (rd_cnt - r0), 0);
    end

    // R6 / R7: reads of several lengths and commands
    do_read(8'h85, 1);
    do_read(8'hC3, 2);
    do_read(8'hFF, 3);
    do_read(8'hBF, 2);

    // R1: aborted command leaves nothing behind
    c0 = cmd_cnt; w0 = wr_cnt;
    begin_xfer();
    for (int i = 0; i < 5; i++) sbit(1'b1, lo, hi, oe);
    end_xfer();
    chk(cmd_cnt == c0, "R1", cmd_cnt - c0, 0);
    begin_xfer();
    send_byte(8'h82);
    send_byte(8'h3C);
    end_xfer();
    chk(last_cmd == 8'h82 && last_wr == 8'h3C, "R1", {last_cmd, last_wr}, 16'h823C);
    chk(wr_cnt == w0 + 1, "R1", wr_cnt - w0, 1);

    // R1 / R8: read cut mid-byte releases the line
    begin_xfer();
    send_byte(8'h87);
    for (int i = 0; i < 3; i++) sbit(1'b0, lo, hi, oe);
    chk(oe == 1'b1, "R8", oe, 1);
    end_xfer();
    chk(dio_oe == 1'b0, "R1", dio_oe, 0);
    do_read(8'h89, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule